// File: doc/BRIEF.md
# Frame Buffer Slot Manager

This block decides which frame store in external memory a video writer fills and which one a video reader scans out. The writer and the reader run at unrelated frame rates. The manager keeps three indices: the slot being written, the newest finished frame, and the slot the reader currently holds. At the start of each frame the writer asks for a slot and is given a base address. At the end of the frame it reports done, with a flag that marks the frame as damaged. At the start of each output frame the reader asks for a frame. It receives the newest finished frame if it has not read that frame yet. Otherwise it is told to scan its current slot again.

Progressive video uses three slots or two slots, selected by a parameter. Interlaced fields always use two slots. Each finished frame keeps its width, its height and the number of auxiliary packets that go with it, and these values are returned with every grant of that frame. A run-time enable blocks reader grants while writing goes on. Four saturating counters record completed, dropped, repeated and broken frames.

Top module: `fb_slot_mgr`

## Requirements
- R1: A slot is identified by index 0, 1 or 2, and its base address is BASE_ADDR + index × SLOT_STRIDE. Progressive requests in triple mode may be granted any of the three slots. Interlaced requests, and every request in double mode, are granted only slot 0 or slot 1.
- R2: The writer is never granted the slot held by the reader. In triple mode it is also never granted the newest finished frame, and it takes the lowest-numbered slot that remains.
- R3: When a frame completes while the previous newest frame has not been read, the older frame is lost, `cnt_dropped` increments, and the next read returns the new frame.
- R4: When the reader asks while no unread finished frame exists, and it already holds a slot, it gets that slot again with `rd_repeat`=1, and `cnt_repeated` increments.
- R5: With DROP_BROKEN=1, a frame that completes with `wr_broken`=1 never becomes readable, its slot becomes free again, `cnt_broken` increments and `cnt_written` does not.
- R6: The width and height (up to 16384, 15 bits) and the auxiliary packet count (0–255) given at completion are returned with every grant of that frame, including repeats.
- R7: While `out_en`=0, every reader request is answered with `rd_valid`=0 and changes no counter. Frames written during that time become readable once `out_en` returns to 1.
- R8: Before the first frame completes, a reader request is answered with `rd_valid`=0.
- R9: The counters saturate at 2^CNT_W−1, and a `cnt_clr` pulse sets all four to zero.
- R10: `rd_grant` pulses in the cycle after a `rd_req` cycle. `wr_grant` pulses in the cycle after a `wr_req` when a slot is available and `rd_req` is low in that cycle.
- R11: In two-slot operation, when the only slot the reader does not hold is an unread finished frame, the writer is given that slot and the frame is counted as dropped.
- R12: `cnt_written` counts every frame that completes without being discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Allows reader grants when high |
| cnt_clr | input | 1 | Clears all statistics counters |
| wr_req | input | 1 | Writer start-of-frame request |
| wr_interlaced | input | 1 | The requested frame is an interlaced field |
| wr_done | input | 1 | Writer end-of-frame pulse |
| wr_broken | input | 1 | The completed frame is damaged |
| wr_width | input | DIM_W | Width of the completed frame |
| wr_height | input | DIM_W | Height of the completed frame |
| wr_aux | input | AUX_W | Auxiliary packet count of the completed frame |
| wr_grant | output | 1 | Writer slot granted |
| wr_slot | output | 2 | Granted writer slot index |
| wr_base | output | ADDR_W | Granted writer base address |
| rd_req | input | 1 | Reader start-of-frame request |
| rd_grant | output | 1 | Reader response strobe |
| rd_valid | output | 1 | The response carries a frame |
| rd_repeat | output | 1 | The frame is a repeat |
| rd_slot | output | 2 | Reader slot index |
| rd_base | output | ADDR_W | Reader base address |
| rd_width | output | DIM_W | Frame width |
| rd_height | output | DIM_W | Frame height |
| rd_aux | output | AUX_W | Auxiliary packet count |
| cnt_written | output | CNT_W | Completed frames |
| cnt_dropped | output | CNT_W | Dropped frames |
| cnt_repeated | output | CNT_W | Repeated frames |
| cnt_broken | output | CNT_W | Broken frames |

## Verification
The forced overwrite in two-slot operation is hard to reach from the ports. It needs the reader to hold one slot while an unread frame sits in the other, and that happens only after a specific sequence of progressive writes, reads and broken frames. The stimulus first walks triple mode through drop, repeat and broken-frame cases that leave a known slot held. It then issues a run of interlaced writes with no reads, so every write after the first must take the unread slot. The bench predicts the granted slots and the drop count arithmetically. A narrow counter width in the bench lets a run of repeats reach saturation.

// File: rtl/fb_slot_pkg.sv
package fb_slot_pkg;
  localparam int MAX_SLOTS = 3;
  localparam int SLOT_W    = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  localparam int CTR_NUM   = 4;
  localparam int CTR_WR    = 0;
  localparam int CTR_DROP  = 1;
  localparam int CTR_REP   = 2;
  localparam int CTR_BRK   = 3;
endpackage

// File: rtl/fb_slot_pick.sv
module fb_slot_pick
  import fb_slot_pkg::*;
#(
  parameter int N = MAX_SLOTS
) (
  input  logic          three,
  input  logic [N-1:0]  avoid,
  input  logic [N-1:0]  newest,
  output logic          found,
  output slot_t         slot,
  output logic          took_newest
);
  logic [N-1:0] in_range;
  logic [N-1:0] pref;
  logic [N-1:0] any_ok;

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g < 2) begin : g_low
      assign in_range[g] = 1'b1;
    end else begin : g_high
      assign in_range[g] = three;
    end
    assign any_ok[g] = in_range[g] & ~avoid[g];
    assign pref[g]   = any_ok[g] & ~newest[g];
  end

  always_comb begin
    found       = 1'b0;
    slot        = '0;
    took_newest = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (any_ok[i] && !found) begin
        slot = slot_t'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (pref[i]) begin
        slot  = slot_t'(i);
        found = 1'b1;
      end
    end
    if (!found && |any_ok) begin
      found       = 1'b1;
      took_newest = 1'b1;
    end
  end
endmodule

// File: rtl/fb_slot_meta.sv
module fb_slot_meta
  import fb_slot_pkg::*;
#(
  parameter int N = MAX_SLOTS,
  parameter int W = 38
) (
  input  logic         clk,
  input  logic         we,
  input  slot_t        waddr,
  input  logic [W-1:0] wdata,
  input  logic         re,
  input  slot_t        raddr,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fb_sat_ctr.sv
module fb_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)       q <= '0;
    else if (inc && ~&q)  q <= q + 1'b1;
  end
endmodule

// File: rtl/fb_slot_mgr.sv
module fb_slot_mgr
  import fb_slot_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
  parameter logic [ADDR_W-1:0] SLOT_STRIDE = 32'h0100_0000,
  parameter bit                TRIPLE      = 1'b1,
  parameter bit                DROP_BROKEN = 1'b1,
  parameter int                DIM_W       = 15,
  parameter int                AUX_W       = 8,
  parameter int                CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_en,
  input  logic              cnt_clr,
  input  logic              wr_req,
  input  logic              wr_interlaced,
  input  logic              wr_done,
  input  logic              wr_broken,
  input  logic [DIM_W-1:0]  wr_width,
  input  logic [DIM_W-1:0]  wr_height,
  input  logic [AUX_W-1:0]  wr_aux,
  output logic              wr_grant,
  output logic [1:0]        wr_slot,
  output logic [ADDR_W-1:0] wr_base,
  input  logic              rd_req,
  output logic              rd_grant,
  output logic              rd_valid,
  output logic              rd_repeat,
  output logic [1:0]        rd_slot,
  output logic [ADDR_W-1:0] rd_base,
  output logic [DIM_W-1:0]  rd_width,
  output logic [DIM_W-1:0]  rd_height,
  output logic [AUX_W-1:0]  rd_aux,
  output logic [CNT_W-1:0]  cnt_written,
  output logic [CNT_W-1:0]  cnt_dropped,
  output logic [CNT_W-1:0]  cnt_repeated,
  output logic [CNT_W-1:0]  cnt_broken
);
  localparam int META_W = 2 * DIM_W + AUX_W;

  // slot ownership state
  logic  wr_busy, wr_pend, pend_il, wr_ilace_q;
  slot_t wslot;
  logic  lat_vld, lat_unread;
  slot_t lslot;
  logic  rd_hold;
  slot_t rslot;

  // writer allocation
  logic                 cur_il, use_three, req_any;
  logic [MAX_SLOTS-1:0] avoid_m, newest_m;
  logic                 p_found, p_newest, do_grant;
  slot_t                p_slot;

  assign cur_il    = wr_req ? wr_interlaced : pend_il;
  assign use_three = TRIPLE && !cur_il;
  assign req_any   = (wr_req || wr_pend) && !wr_busy;

  always_comb begin
    avoid_m  = '0;
    newest_m = '0;
    if (rd_hold) avoid_m[rslot]  = 1'b1;
    if (lat_vld) newest_m[lslot] = 1'b1;
  end

  fb_slot_pick #(.N(MAX_SLOTS)) u_pick (
    .three       (use_three),
    .avoid       (avoid_m),
    .newest      (newest_m),
    .found       (p_found),
    .slot        (p_slot),
    .took_newest (p_newest)
  );

  assign do_grant = req_any && p_found && !rd_req;

  // reader decision
  logic  rd_take, rd_rep;
  slot_t rd_sel;
  assign rd_take = rd_req && out_en && lat_vld && lat_unread;
  assign rd_rep  = rd_req && out_en && !rd_take && rd_hold;
  assign rd_sel  = rd_take ? lslot : rslot;

  // completion
  logic done_ok, done_brk, drop_done, drop_grant;
  assign done_ok    = wr_done && wr_busy && !(wr_broken && DROP_BROKEN);
  assign done_brk   = wr_done && wr_busy && wr_broken;
  assign drop_done  = done_ok && lat_vld && lat_unread && !rd_take;
  assign drop_grant = do_grant && p_newest && lat_unread;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_busy    <= 1'b0;
      wr_pend    <= 1'b0;
      pend_il    <= 1'b0;
      wr_ilace_q <= 1'b0;
      wslot      <= '0;
      lat_vld    <= 1'b0;
      lat_unread <= 1'b0;
      lslot      <= '0;
      rd_hold    <= 1'b0;
      rslot      <= '0;
      wr_grant   <= 1'b0;
      wr_slot    <= '0;
      wr_base    <= '0;
      rd_grant   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_repeat  <= 1'b0;
      rd_slot    <= '0;
      rd_base    <= '0;
    end else begin
      wr_grant <= do_grant;
      if (do_grant) begin
        wr_busy    <= 1'b1;
        wslot      <= p_slot;
        wr_slot    <= p_slot;
        wr_base    <= BASE_ADDR + SLOT_STRIDE * ADDR_W'(p_slot);
        wr_pend    <= 1'b0;
        wr_ilace_q <= cur_il;
        if (p_newest) begin
          lat_vld    <= 1'b0;
          lat_unread <= 1'b0;
        end
      end else if (wr_req && !wr_busy) begin
        wr_pend <= 1'b1;
        pend_il <= wr_interlaced;
      end

      rd_grant  <= rd_req;
      rd_valid  <= rd_take || rd_rep;
      rd_repeat <= rd_rep;
      if (rd_take || rd_rep) begin
        rd_slot <= rd_sel;
        rd_base <= BASE_ADDR + SLOT_STRIDE * ADDR_W'(rd_sel);
      end
      if (rd_take) begin
        rd_hold    <= 1'b1;
        rslot      <= lslot;
        lat_unread <= 1'b0;
      end

      if (wr_done && wr_busy) begin
        wr_busy <= 1'b0;
        if (done_ok) begin
          lat_vld    <= 1'b1;
          lat_unread <= 1'b1;
          lslot      <= wslot;
        end
      end
    end
  end

  // per-slot frame description
  logic [META_W-1:0] meta_q;
  fb_slot_meta #(.N(MAX_SLOTS), .W(META_W)) u_meta (
    .clk   (clk),
    .we    (done_ok),
    .waddr (wslot),
    .wdata ({wr_width, wr_height, wr_aux}),
    .re    (rd_take || rd_rep),
    .raddr (rd_sel),
    .rdata (meta_q)
  );
  assign {rd_width, rd_height, rd_aux} = meta_q;

  // statistics
  logic [CTR_NUM-1:0] ctr_inc;
  logic [CNT_W-1:0]   ctr_q [CTR_NUM];
  assign ctr_inc[CTR_WR]   = done_ok;
  assign ctr_inc[CTR_DROP] = drop_done || drop_grant;
  assign ctr_inc[CTR_REP]  = rd_rep;
  assign ctr_inc[CTR_BRK]  = done_brk;

  for (genvar c = 0; c < CTR_NUM; c++) begin : g_ctr
    fb_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr),
      .inc (ctr_inc[c]),
      .q   (ctr_q[c])
    );
  end

  assign cnt_written  = ctr_q[CTR_WR];
  assign cnt_dropped  = ctr_q[CTR_DROP];
  assign cnt_repeated = ctr_q[CTR_REP];
  assign cnt_broken   = ctr_q[CTR_BRK];
endmodule

// File: rtl/fb_slot_mgr_chk.sv
module fb_slot_mgr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             out_en,
  input logic             cnt_clr,
  input logic             rd_req,
  input logic             rd_grant,
  input logic             rd_valid,
  input logic             rd_repeat,
  input logic             wr_grant,
  input logic [1:0]       wr_slot,
  input logic             wr_ilace_q,
  input logic             rd_hold,
  input logic [1:0]       rslot,
  input logic [CNT_W-1:0] cnt_repeated
);
  // R1
  ilace_two_slots_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_grant && wr_ilace_q) |-> (wr_slot <= 2'd1));
  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_grant |-> (wr_slot <= 2'd2));
  // R2
  no_reader_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_grant && rd_hold) |-> (wr_slot != rslot));
  // R10
  rd_grant_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rd_grant |-> $past(rd_req));
  // R10
  wr_grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_grant |=> !wr_grant);
  // R7
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_grant && rd_valid) |-> $past(out_en));
  // R4
  repeat_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_repeat |-> (rd_valid && rd_grant));
  // R9
  rep_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    ((&cnt_repeated) && !cnt_clr) |=> (&cnt_repeated));
endmodule

bind fb_slot_mgr fb_slot_mgr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .out_en       (out_en),
  .cnt_clr      (cnt_clr),
  .rd_req       (rd_req),
  .rd_grant     (rd_grant),
  .rd_valid     (rd_valid),
  .rd_repeat    (rd_repeat),
  .wr_grant     (wr_grant),
  .wr_slot      (wr_slot),
  .wr_ilace_q   (wr_ilace_q),
  .rd_hold      (rd_hold),
  .rslot        (rslot),
  .cnt_repeated (cnt_repeated)
);

// File: tb/fb_slot_mgr_tb.sv
module fb_slot_mgr_tb;
  localparam int          ADDR_W = 32;
  localparam logic [31:0] BASE   = 32'h0000_1000;
  localparam logic [31:0] STRIDE = 32'h0000_0100;
  localparam int          DIM_W  = 15;
  localparam int          AUX_W  = 8;
  localparam int          CNT_W  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic out_en = 1'b1, cnt_clr = 1'b0;
  logic wr_req = 1'b0, wr_interlaced = 1'b0, wr_done = 1'b0, wr_broken = 1'b0;
  logic [DIM_W-1:0] wr_width = '0, wr_height = '0;
  logic [AUX_W-1:0] wr_aux = '0;
  logic wr_grant, rd_req = 1'b0, rd_grant, rd_valid, rd_repeat;
  logic [1:0] wr_slot, rd_slot;
  logic [ADDR_W-1:0] wr_base, rd_base;
  logic [DIM_W-1:0] rd_width, rd_height;
  logic [AUX_W-1:0] rd_aux;
  logic [CNT_W-1:0] cnt_written, cnt_dropped, cnt_repeated, cnt_broken;

  always #2 clk = ~clk;

  fb_slot_mgr #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .SLOT_STRIDE(STRIDE), .TRIPLE(1'b1),
    .DROP_BROKEN(1'b1), .DIM_W(DIM_W), .AUX_W(AUX_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .out_en(out_en), .cnt_clr(cnt_clr),
    .wr_req(wr_req), .wr_interlaced(wr_interlaced), .wr_done(wr_done),
    .wr_broken(wr_broken), .wr_width(wr_width), .wr_height(wr_height),
    .wr_aux(wr_aux), .wr_grant(wr_grant), .wr_slot(wr_slot), .wr_base(wr_base),
    .rd_req(rd_req), .rd_grant(rd_grant), .rd_valid(rd_valid),
    .rd_repeat(rd_repeat), .rd_slot(rd_slot), .rd_base(rd_base),
    .rd_width(rd_width), .rd_height(rd_height), .rd_aux(rd_aux),
    .cnt_written(cnt_written), .cnt_dropped(cnt_dropped),
    .cnt_repeated(cnt_repeated), .cnt_broken(cnt_broken)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  logic [1:0] g_slot;

  task automatic write_frame(input bit il, input bit brk, input int w, input int h, input int aux);
    @(negedge clk);
    wr_req = 1'b1; wr_interlaced = il;
    @(negedge clk);
    wr_req = 1'b0;
    chk_eq("R10 wr_grant after request", wr_grant, 1);
    g_slot = wr_slot;
    chk_eq("R1 wr_base", wr_base, BASE + STRIDE * wr_slot);
    wr_done = 1'b1; wr_broken = brk;
    wr_width = DIM_W'(w); wr_height = DIM_W'(h); wr_aux = AUX_W'(aux);
    @(negedge clk);
    wr_done = 1'b0; wr_broken = 1'b0;
  endtask

  logic       r_valid, r_rep;
  logic [1:0] r_slot;
  int         r_w, r_h, r_aux;

  task automatic read_frame();
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk_eq("R10 rd_grant after request", rd_grant, 1);
    r_valid = rd_valid; r_rep = rd_repeat; r_slot = rd_slot;
    r_w = int'(rd_width); r_h = int'(rd_height); r_aux = int'(rd_aux);
    if (rd_valid) chk_eq("R1 rd_base", rd_base, BASE + STRIDE * rd_slot);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int exp_drop;
    bit unread;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("reset wr_grant", wr_grant, 0);
    chk_eq("reset rd_grant", rd_grant, 0);
    chk_eq("R12 reset written", cnt_written, 0);
    chk_eq("R9 reset repeated", cnt_repeated, 0);

    read_frame();
    chk_eq("R8 no frame yet", r_valid, 0);

    write_frame(0, 0, 16384, 2160, 255);
    chk_eq("R1 first slot", g_slot, 0);
    chk_eq("R12 written after A", cnt_written, 1);
    read_frame();
    chk_eq("R6 valid A", r_valid, 1);
    chk_eq("R6 slot A", r_slot, 0);
    chk_eq("R6 width A", r_w, 16384);
    chk_eq("R6 height A", r_h, 2160);
    chk_eq("R6 aux A", r_aux, 255);
    chk_eq("R4 first read not repeat", r_rep, 0);
    read_frame();
    chk_eq("R4 repeat flag", r_rep, 1);
    chk_eq("R4 repeat slot", r_slot, 0);
    chk_eq("R6 repeat aux", r_aux, 255);
    chk_eq("R4 repeat count", cnt_repeated, 1);

    write_frame(0, 0, 100, 50, 1);
    chk_eq("R2 B avoids held slot", g_slot, 1);
    write_frame(0, 0, 200, 60, 2);
    chk_eq("R2 C avoids held and newest", g_slot, 2);
    chk_eq("R3 drop after C", cnt_dropped, 1);
    write_frame(0, 0, 300, 70, 3);
    chk_eq("R2 D slot", g_slot, 1);
    chk_eq("R3 drop after D", cnt_dropped, 2);
    chk_eq("R12 written after D", cnt_written, 4);
    read_frame();
    chk_eq("R3 newest slot", r_slot, 1);
    chk_eq("R3 newest width", r_w, 300);
    chk_eq("R6 newest aux", r_aux, 3);

    write_frame(0, 1, 400, 80, 4);
    chk_eq("R2 E slot", g_slot, 0);
    chk_eq("R5 broken count", cnt_broken, 1);
    chk_eq("R5 written unchanged", cnt_written, 4);
    read_frame();
    chk_eq("R5 broken not readable", r_rep, 1);
    chk_eq("R5 repeat slot", r_slot, 1);
    chk_eq("R6 repeat keeps width", r_w, 300);
    chk_eq("R4 repeat count 2", cnt_repeated, 2);

    out_en = 1'b0;
    read_frame();
    chk_eq("R7 gated read invalid", r_valid, 0);
    chk_eq("R7 no repeat count", cnt_repeated, 2);
    write_frame(0, 0, 500, 90, 5);
    chk_eq("R5 freed slot reused", g_slot, 0);
    chk_eq("R7 write continues", cnt_written, 5);
    out_en = 1'b1;
    read_frame();
    chk_eq("R7 frame after enable", r_slot, 0);
    chk_eq("R7 width after enable", r_w, 500);
    chk_eq("R7 fresh frame", r_rep, 0);

    exp_drop = 2;
    unread = 0;
    for (int i = 0; i < 6; i++) begin
      write_frame(1, 0, 600 + i, 100 + i, 10 + i);
      chk(g_slot <= 1, "R1 interlaced slot", g_slot, 1);
      chk(g_slot != 0, "R2 interlaced avoids held", g_slot, 1);
      if (unread) exp_drop++;
      unread = 1;
    end
    chk_eq("R11 forced drops", cnt_dropped, exp_drop);
    chk_eq("R12 written after fields", cnt_written, 11);
    read_frame();
    chk_eq("R11 newest field slot", r_slot, 1);
    chk_eq("R11 newest field width", r_w, 605);
    chk_eq("R11 newest field aux", r_aux, 15);

    for (int i = 0; i < 20; i++) read_frame();
    chk_eq("R9 repeat saturates", cnt_repeated, 15);
    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    chk_eq("R9 clear repeated", cnt_repeated, 0);
    chk_eq("R9 clear written", cnt_written, 0);
    chk_eq("R9 clear dropped", cnt_dropped, 0);
    chk_eq("R9 clear broken", cnt_broken, 0);
    summary();
  end
endmodule